// File: doc/BRIEF.md
# Conditioner-Aware Enable Delay Controller

This controller sits between the software enable of an entropy module and the rest of the entropy pipeline. When software turns the module off, the conditioner may still be hashing a block that it accepted earlier. The controller keeps the gated enable low until the conditioner has finished that block. Only after that does a new software enable reach the noise source and the sampling pipeline.

The release event is the conditioner's per-block completion pulse, which fires at the end of every block the hash engine processes. It is not the done strobe of a final operation, because that strobe fires only for a small share of operations. Waiting for that strobe could hang forever: the noise source would stay off, no bits would arrive, and the conditioner would never run again.

The gated enable also drives the clear inputs of the pipeline packers. A parameterised vector of active-high clears holds every packer in reset whenever the gated enable is low.

Top module: `cond_en_gate`

## Requirements
- R1: After reset, `en_delayed_o` is 0 and every bit of `pack_clr_o` is 1. The controller starts in its idle state.
- R2: From the idle state, `module_en_i` sampled high at a clock edge sets `en_delayed_o` to 1 right after that edge. `en_delayed_o` never rises unless `module_en_i` was high at the previous edge.
- R3: While enabled, `module_en_i` sampled low drops `en_delayed_o` after that edge. If `cond_busy_i` was 0 at that edge, the controller returns to idle, and a later enable passes after one registered cycle.
- R4: While enabled, `module_en_i` low together with `cond_busy_i` high and `blk_done_i` low puts the controller in a waiting state. `en_delayed_o` stays 0 until `blk_done_i` is sampled high.
- R5: In the waiting state, `module_en_i` high has no effect. After `blk_done_i` is sampled high, the controller goes to idle. A held-high enable then raises `en_delayed_o` one edge later.
- R6: A `blk_done_i` pulse sampled at the same edge as the disable is not lost. The controller goes directly to idle.
- R7: Every bit of `pack_clr_o` equals the inverse of `en_delayed_o` on every cycle.
- R8: In the waiting state, `cond_busy_i` falling without a `blk_done_i` pulse does not release the controller.
- R9: While enabled with `module_en_i` high, `blk_done_i` pulses have no effect on `en_delayed_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| module_en_i | input | 1 | Software enable of the entropy module |
| cond_busy_i | input | 1 | Conditioner holds data that is not yet processed |
| blk_done_i | input | 1 | One-cycle pulse: the hash engine finished a block |
| en_delayed_o | output | 1 | Gated enable for the noise source and pipeline |
| pack_clr_o | output | NUM_PACKERS | Active-high clears for the pipeline packers |

## Verification
The checker watches several properties on every cycle:
- the packer clears always mirror the gated enable;
- the gated enable never rises without a prior software enable;
- a disable always drops the output;
- the waiting state can be left only through a completion pulse, and such a pulse always leads to idle.

Other behaviours need sequences from the bench scenarios:
- a re-enable ignored while waiting;
- busy dropping with no pulse;
- a pulse arriving in the same cycle as the disable;
- a reset taken in the middle of a wait.

// File: rtl/cond_en_gate_pkg.sv
package cond_en_gate_pkg;
   typedef enum logic [1:0] {
      ST_IDLE      = 2'b00,
      ST_ENABLED   = 2'b01,
      ST_WAIT_COND = 2'b10
   } gate_state_e;
endpackage

// File: rtl/cond_en_gate_fsm.sv
module cond_en_gate_fsm
   import cond_en_gate_pkg::*;
(
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        module_en_i,
   input  logic        cond_busy_i,
   input  logic        blk_done_i,
   output gate_state_e state_o
);
   gate_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (module_en_i) state_d = ST_ENABLED;
         end
         ST_ENABLED: begin
            if (!module_en_i) begin
               // a completion pulse arriving with the disable counts as done
               state_d = (cond_busy_i && !blk_done_i) ? ST_WAIT_COND : ST_IDLE;
            end
         end
         ST_WAIT_COND: begin
            // only the per-block pulse releases; enable and busy are ignored
            if (blk_done_i) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= ST_IDLE;
      else         state_q <= state_d;
   end

   assign state_o = state_q;
endmodule

// File: rtl/cond_en_gate_drv.sv
module cond_en_gate_drv
   import cond_en_gate_pkg::*;
#(
   parameter int unsigned NUM_PACKERS = 3
) (
   input  gate_state_e            state_i,
   output logic                   en_o,
   output logic [NUM_PACKERS-1:0] clr_o
);
   if (NUM_PACKERS < 1) begin : g_bad_cfg
      $error("NUM_PACKERS must be at least 1");
   end

   assign en_o = (state_i == ST_ENABLED);

   for (genvar g = 0; g < NUM_PACKERS; g++) begin : g_clr
      assign clr_o[g] = (state_i != ST_ENABLED);
   end
endmodule

// File: rtl/cond_en_gate.sv
module cond_en_gate
   import cond_en_gate_pkg::*;
#(
   parameter int unsigned NUM_PACKERS = 3
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   module_en_i,
   input  logic                   cond_busy_i,
   input  logic                   blk_done_i,
   output logic                   en_delayed_o,
   output logic [NUM_PACKERS-1:0] pack_clr_o
);
   gate_state_e state;

   cond_en_gate_fsm u_fsm (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .module_en_i (module_en_i),
      .cond_busy_i (cond_busy_i),
      .blk_done_i  (blk_done_i),
      .state_o     (state)
   );

   cond_en_gate_drv #(.NUM_PACKERS(NUM_PACKERS)) u_drv (
      .state_i (state),
      .en_o    (en_delayed_o),
      .clr_o   (pack_clr_o)
   );
endmodule

// File: rtl/cond_en_gate_chk.sv
module cond_en_gate_chk
   import cond_en_gate_pkg::*;
#(
   parameter int unsigned NUM_PACKERS = 3
) (
   input logic                   clk_i,
   input logic                   rst_ni,
   input logic                   module_en_i,
   input logic                   cond_busy_i,
   input logic                   blk_done_i,
   input logic                   en_delayed_o,
   input logic [NUM_PACKERS-1:0] pack_clr_o,
   input gate_state_e            state
);
   p_clr_mirror_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pack_clr_o == {NUM_PACKERS{~en_delayed_o}});

   p_rise_needs_en_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(en_delayed_o) |-> $past(module_en_i));

   p_drop_on_disable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !module_en_i |=> !en_delayed_o);

   p_hold_wait_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state == ST_WAIT_COND && !blk_done_i) |=> (state == ST_WAIT_COND && !en_delayed_o));

   p_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state == ST_WAIT_COND && blk_done_i) |=> state == ST_IDLE);

   p_same_cycle_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state == ST_ENABLED && !module_en_i && blk_done_i) |=> state == ST_IDLE);

   p_done_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state == ST_ENABLED && module_en_i) |=> en_delayed_o);
endmodule

bind cond_en_gate cond_en_gate_chk #(.NUM_PACKERS(NUM_PACKERS)) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .module_en_i  (module_en_i),
   .cond_busy_i  (cond_busy_i),
   .blk_done_i   (blk_done_i),
   .en_delayed_o (en_delayed_o),
   .pack_clr_o   (pack_clr_o),
   .state        (state)
);

// File: tb/cond_en_gate_test.sv
module cond_en_gate_test;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 3;
   localparam int NVEC = 17;
   // {module_en, busy, blk_done, expected en after the next edge}
   localparam logic [3:0] VEC [NVEC] = '{
      4'b0000, // idle
      4'b1001, // R2 enable passes
      4'b1011, // R9 pulse while enabled ignored
      4'b0000, // R3 disable, not busy
      4'b1001, // R3 re-enable after one cycle
      4'b0100, // R4 disable while busy -> wait
      4'b0100, // R4 stays low
      4'b1100, // R5 enable ignored while waiting
      4'b1000, // R8 busy drops, no pulse
      4'b1010, // R5 pulse -> idle
      4'b1001, // R5 enable passes
      4'b0110, // R6 pulse with disable
      4'b1001, // R6 no wait
      4'b0100, // R4 wait again
      4'b0010, // R5 pulse while disabled
      4'b0000, // idle
      4'b1001  // R2 enable
   };

   logic clk = 0, rst_n = 0, en = 0, busy = 0, done = 0;
   logic en_d;
   logic [NP-1:0] clr;
   int n_tests = 0, n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cond_en_gate #(.NUM_PACKERS(NP)) uut (
      .clk_i(clk), .rst_ni(rst_n), .module_en_i(en), .cond_busy_i(busy),
      .blk_done_i(done), .en_delayed_o(en_d), .pack_clr_o(clr));

   task automatic check(input string req, input logic exp);
      n_tests++;
      if (en_d !== exp || clr !== {NP{~exp}}) begin
         n_fail++;
         $display("FAIL %s: en=%0b clr=%b expected en=%0b clr=%b", req, en_d, clr, exp, {NP{~exp}});
      end
   endtask

   task automatic step(input logic e, input logic b, input logic d);
      en = e; busy = b; done = d;
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset state", 1'b0);
      rst_n = 1;
      @(negedge clk);
      check("R1 after reset release", 1'b0);
      for (int i = 0; i < NVEC; i++) begin
         step(VEC[i][3], VEC[i][2], VEC[i][1]);
         check($sformatf("R2-table row %0d (R7 clr)", i), VEC[i][0]);
      end
      // directed: reset in the middle of a wait
      step(1'b0, 1'b1, 1'b0);
      check("R4 waiting", 1'b0);
      rst_n = 0;
      @(negedge clk);
      check("R1 reset while waiting", 1'b0);
      rst_n = 1;
      step(1'b1, 1'b1, 1'b0);
      check("R1 reset clears wait, R2 enable passes", 1'b1);
      // long wait with busy toggling, no pulse
      step(1'b0, 1'b1, 1'b0);
      for (int k = 0; k < 6; k++) begin
         step(1'b1, k[0], 1'b0);
         check("R8 no release without pulse", 1'b0);
      end
      step(1'b1, 1'b0, 1'b1);
      check("R5 pulse releases to idle", 1'b0);
      step(1'b1, 1'b0, 1'b0);
      check("R5 enable after release", 1'b1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule